// File: doc/BRIEF.md
# 4:2:2 Chroma Decimator and Word Multiplexer

This block takes one 4:4:4 luma/colour-difference pixel every two clocks, together with horizontal blanking, vertical blanking and field flags, and reduces the colour-difference data to 4:2:2. Each pair of active pixels keeps only one Cb and one Cr sample. The other two are dropped, and a select input decides which pixel of the pair supplies them. The reduced data leave in one of two ways. The first is a pixel-rate pair of luma and alternating Cb/Cr. The second is a single word stream on the 2x clock that interleaves Cb, Y, Cr, Y and carries generated start-of-active and end-of-active timing reference words.

The clock is the line-locked 2x clock. Its edges alternate between idle and load, and the first load edge is the second edge after reset. Each pixel is captured on a load edge, and the input must be held across both clocks of its pixel period. A four-pixel internal line lets the block see two pixels ahead and one pixel behind the pixel it emits. It uses that view to place the end-of-active header on the first two blanking pixels of a line and the start-of-active header on the last two. Lines are expected to have at least four blanking pixels and an even number of active pixels.

Top module: `ycc422_mux`

## Requirements
- R1: With `dec_en` low, `y_o`, `u_o` and `v_o` carry the raw Y, Cb and Cr of a pixel. They change on the sixth clock edge after the load edge that captured it and hold for two clocks.
- R2: With `dec_en` high, `v_o` is 0. On an active pixel `u_o` carries Cb when the pixel's parity is even and Cr when it is odd. Parity counts active pixels from 0 at the first active pixel after horizontal blanking.
- R3: With `csel` low, both kept colour-difference samples of a pair come from the even pixel. With `csel` high, both come from the odd pixel.
- R4: With `dec_en` high and horizontal blanking on the pixel, `y_o` is 040h, `u_o` is 200h and `v_o` is 0.
- R5: `ser_o` is 0 unless both `dec_en` and `mux_en` are high.
- R6: In stream mode an active pixel (both blanking flags low) emits two words, on the fifth and sixth clock edges after its load edge. An even pixel emits its kept Cb then Y, and an odd pixel emits its kept Cr then Y, giving the order Cb, Y, Cr, Y.
- R7: Active stream words are clipped to the range 004h..3FBh, so 000h and 3FFh never appear in them.
- R8: The first two blanking pixels after active pixels emit the end-of-active header: 3FFh, 000h, 000h, then a status word with H=1.
- R9: The last two blanking pixels before active pixels emit the start-of-active header: 3FFh, 000h, 000h, then a status word with H=0.
- R10: The status word has bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1..0 = 0. F is the field flag and V is the vertical blanking flag of that pixel.
- R11: Any other stream word on a blanking pixel, or on a pixel in vertical blanking, alternates 200h (first word) and 040h (second word).
- R12: While `rst_n` is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_en | input | 1 | Chroma decimation enable |
| mux_en | input | 1 | Word-stream enable (effective only with `dec_en`) |
| csel | input | 1 | Kept chroma phase: 0 even pixel, 1 odd pixel |
| y_i | input | W | Luma input |
| cb_i | input | W | Blue colour-difference input |
| cr_i | input | W | Red colour-difference input |
| hblank_i | input | 1 | Horizontal blanking flag |
| vblank_i | input | 1 | Vertical blanking flag |
| field_i | input | 1 | Field flag |
| y_o | output | W | Pixel-rate luma |
| u_o | output | W | Pixel-rate Cb (4:4:4) or multiplexed Cb/Cr |
| v_o | output | W | Pixel-rate Cr (4:4:4) or 0 |
| ser_o | output | W | Word stream on the 2x clock |

## Verification
The bench builds the block with its default 10-bit word width. At that width the header words, fill codes, status-word bit positions and clip bounds 004h/3FBh take their exact values, and the test data can land on 000h, 003h, 3FCh and 3FFh to exercise both clip edges. Lines of six blanking and eight active pixels bring both headers and both chroma parities within reach of each run. Four lines step through every combination of field and vertical blanking in the status word. Separate runs cover each mode pairing and both `csel` phases.

// File: rtl/ycc422_mux.sv
module ycc422_mux #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_en,
  input  logic         mux_en,
  input  logic         csel,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] cb_i,
  input  logic [W-1:0] cr_i,
  input  logic         hblank_i,
  input  logic         vblank_i,
  input  logic         field_i,
  output logic [W-1:0] y_o,
  output logic [W-1:0] u_o,
  output logic [W-1:0] v_o,
  output logic [W-1:0] ser_o
);
  localparam int DEPTH = 4;
  localparam logic [W-1:0] ZERO  = '0;
  localparam logic [W-1:0] ONES  = '1;
  localparam logic [W-1:0] UNIT  = 1;
  localparam logic [W-1:0] LO    = UNIT << (W - 8);
  localparam logic [W-1:0] HI    = ONES - LO;
  localparam logic [W-1:0] BLK_C = UNIT << (W - 1);
  localparam logic [W-1:0] BLK_Y = UNIT << (W - 4);

  typedef struct packed {
    logic         hb;
    logic         vb;
    logic         f;
    logic         fb;
    logic         par;
    logic [W-1:0] y;
    logic [W-1:0] cb;
    logic [W-1:0] cr;
  } px_t;

  localparam px_t IDLE = '{hb: 1'b1, vb: 1'b1, f: 1'b0, fb: 1'b0, par: 1'b0,
                           y: '0, cb: '0, cr: '0};

  function automatic logic [W-1:0] clip(input logic [W-1:0] v);
    clip = (v < LO) ? LO : ((v > HI) ? HI : v);
  endfunction

  logic         ph, hb_q, par_q;
  px_t          st [DEPTH];
  px_t          in_p, far, nx, cur, pv;
  logic [W-1:0] ck, xy, word, yn, un, vn;
  logic         eav1, eav2, sav1, sav2;

  wire ser_on = dec_en & mux_en;

  assign in_p = '{hb: hblank_i, vb: vblank_i, f: field_i,
                  fb: hblank_i & ~hb_q, par: ~hblank_i & par_q,
                  y: y_i, cb: cb_i, cr: cr_i};

  assign far = st[0];
  assign nx  = st[1];
  assign cur = st[2];
  assign pv  = st[3];

  assign ck = cur.par ? (csel ? cur.cr : pv.cr)
                      : (csel ? nx.cb  : cur.cb);

  assign eav1 = cur.fb;
  assign eav2 = cur.hb & pv.fb;
  assign sav1 = cur.hb & nx.hb & ~far.hb;
  assign sav2 = cur.hb & ~nx.hb;

  assign xy = {1'b1, cur.f, cur.vb, eav2,
               cur.vb ^ eav2, cur.f ^ eav2, cur.f ^ cur.vb, cur.f ^ cur.vb ^ eav2,
               {(W-8){1'b0}}};

  always_comb begin
    if (!ser_on)                 word = ZERO;
    else if (eav1 || sav1)       word = ph ? ZERO : ONES;
    else if (eav2 || sav2)       word = ph ? xy : ZERO;
    else if (cur.hb || cur.vb)   word = ph ? BLK_Y : BLK_C;
    else                         word = ph ? clip(cur.y) : clip(ck);
  end

  always_comb begin
    if (!dec_en) begin
      yn = cur.y;  un = cur.cb; vn = cur.cr;
    end else if (cur.hb) begin
      yn = BLK_Y;  un = BLK_C;  vn = ZERO;
    end else begin
      yn = cur.y;  un = ck;     vn = ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      hb_q  <= 1'b1;
      par_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) st[i] <= IDLE;
      y_o   <= '0;
      u_o   <= '0;
      v_o   <= '0;
      ser_o <= '0;
    end else begin
      ph    <= ~ph;
      ser_o <= word;
      if (ph) begin
        hb_q  <= hblank_i;
        par_q <= ~hblank_i & ~par_q;
        st[0] <= in_p;
        for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
        y_o <= yn;
        u_o <= un;
        v_o <= vn;
      end
    end
  end
endmodule

module ycc422_mux_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dec_en,
  input logic         mux_en,
  input logic [W-1:0] y_o,
  input logic [W-1:0] u_o,
  input logic [W-1:0] v_o,
  input logic [W-1:0] ser_o
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;
  wire on = dec_en & mux_en;

  p_pix_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({y_o, u_o, v_o}) |=> $stable({y_o, u_o, v_o}));

  p_v_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec_en) && $past(dec_en, 2)) |-> v_o == ZERO);

  p_ser_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(on) |-> ser_o == ZERO);

  p_hdr_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (on && ser_o == ONES) |=> ser_o == ZERO);

  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(on) && $past(on, 2) && $past(ser_o, 2) == ONES &&
     $past(ser_o) == ZERO && ser_o == ZERO)
    |=> (ser_o[W-1] && ser_o[W-5] == (ser_o[W-3] ^ ser_o[W-4]) &&
         ser_o[W-6] == (ser_o[W-2] ^ ser_o[W-4]) &&
         ser_o[W-7] == (ser_o[W-2] ^ ser_o[W-3]) &&
         ser_o[W-8] == (ser_o[W-2] ^ ser_o[W-3] ^ ser_o[W-4])));
endmodule

bind ycc422_mux ycc422_mux_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .mux_en(mux_en),
  .y_o(y_o), .u_o(u_o), .v_o(v_o), .ser_o(ser_o)
);

// File: tb/ycc422_mux_test.sv
module ycc422_mux_test;
  localparam int NB = 6;
  localparam int NA = 8;
  localparam int NL = 4;
  localparam int LL = NB + NA;
  localparam int N  = NL * LL + NB;
  localparam int M  = N - 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_en = 1'b0, mux_en = 1'b0, csel = 1'b0;
  logic [9:0] y_i = '0, cb_i = '0, cr_i = '0;
  logic       hblank_i = 1'b1, vblank_i = 1'b1, field_i = 1'b0;
  logic [9:0] y_o, u_o, v_o, ser_o;

  int checks = 0;
  int errors = 0;

  logic [9:0] ay [N];
  logic [9:0] acb [N];
  logic [9:0] acr [N];
  bit ahb [N], avb [N], af [N], apar [N], eok [N], sok [N];
  int bpos [N], brem [N];

  logic [9:0]  sq [$];
  string       stq [$];
  logic [29:0] pq [$];
  string       ptq [$];

  ycc422_mux uut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .mux_en(mux_en), .csel(csel),
    .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i),
    .hblank_i(hblank_i), .vblank_i(vblank_i), .field_i(field_i),
    .y_o(y_o), .u_o(u_o), .v_o(v_o), .ser_o(ser_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] val(input int k, input int s);
    case ((k + s) % 8)
      0: return 10'h000;
      1: return 10'h3FF;
      2: return 10'h003;
      3: return 10'h3FC;
      default: return 10'((k * 97 + s * 211 + 13) & 1023);
    endcase
  endfunction

  function automatic logic [9:0] cl(input logic [9:0] v);
    if (v < 10'h004) return 10'h004;
    if (v > 10'h3FB) return 10'h3FB;
    return v;
  endfunction

  function automatic logic [9:0] stat(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  // kept chroma for an active pixel (R2, R3)
  function automatic logic [9:0] kept(input int k);
    if (!apar[k]) return csel ? acb[k+1] : acb[k];
    return csel ? acr[k] : acr[k-1];
  endfunction

  task automatic build();
    int p;
    for (int k = 0; k < N; k++) begin
      int l = k / LL;
      int pos = k % LL;
      ahb[k] = (l >= NL) || (pos < NB);
      avb[k] = (l >= NL) ? 1'b1 : l[0];
      af[k]  = (l >= NL) ? 1'b0 : l[1];
      ay[k]  = val(k, 0);
      acb[k] = val(k, 3);
      acr[k] = val(k, 5);
    end
    p = 0;
    for (int k = 0; k < N; k++) begin
      if (ahb[k]) begin apar[k] = 1'b0; p = 0; end
      else begin apar[k] = p[0]; p = p + 1; end
    end
    for (int k = 0; k < N; k++) begin
      if (!ahb[k]) begin bpos[k] = 0; eok[k] = 1'b0; end
      else if (k > 0 && ahb[k-1]) begin bpos[k] = bpos[k-1] + 1; eok[k] = eok[k-1]; end
      else begin bpos[k] = 0; eok[k] = (k > 0); end
    end
    for (int k = N - 1; k >= 0; k--) begin
      if (!ahb[k]) begin brem[k] = 0; sok[k] = 1'b0; end
      else if (k < N - 1 && ahb[k+1]) begin brem[k] = brem[k+1] + 1; sok[k] = sok[k+1]; end
      else begin brem[k] = 1; sok[k] = (k < N - 1); end
    end
  endtask

  task automatic push(input int k);
    logic [9:0] w0, w1;
    string t;
    if (!(dec_en && mux_en)) begin w0 = 0; w1 = 0; t = "R5 stream off"; end
    else if (ahb[k] && eok[k] && bpos[k] == 0) begin w0 = 10'h3FF; w1 = 0; t = "R8 EAV head"; end
    else if (ahb[k] && eok[k] && bpos[k] == 1) begin w0 = 0; w1 = stat(af[k], avb[k], 1'b1); t = "R8 R10 EAV status"; end
    else if (ahb[k] && sok[k] && brem[k] == 2) begin w0 = 10'h3FF; w1 = 0; t = "R9 SAV head"; end
    else if (ahb[k] && sok[k] && brem[k] == 1) begin w0 = 0; w1 = stat(af[k], avb[k], 1'b0); t = "R9 R10 SAV status"; end
    else if (ahb[k] || avb[k]) begin w0 = 10'h200; w1 = 10'h040; t = "R11 fill"; end
    else begin w0 = cl(kept(k)); w1 = cl(ay[k]); t = "R6 R7 active"; end
    sq.push_back(w0); stq.push_back(t);
    sq.push_back(w1); stq.push_back(t);
    if (!dec_en) begin
      pq.push_back({ay[k], acb[k], acr[k]}); ptq.push_back("R1 444");
    end else if (ahb[k]) begin
      pq.push_back({10'h040, 10'h200, 10'h000}); ptq.push_back("R4 blank");
    end else begin
      pq.push_back({ay[k], kept(k), 10'h000}); ptq.push_back("R2 R3 decimated");
    end
  endtask

  task automatic run(input bit d, input bit m, input bit c);
    rst_n = 1'b0;
    dec_en = d; mux_en = m; csel = c;
    hblank_i = 1'b1; vblank_i = 1'b1; field_i = 1'b0;
    build();
    repeat (3) @(negedge clk);
    chk("R12 reset y", y_o, 10'h000);
    chk("R12 reset u", u_o, 10'h000);
    chk("R12 reset v", v_o, 10'h000);
    chk("R12 reset ser", ser_o, 10'h000);
    rst_n = 1'b1;
    fork
      begin
        for (int k = 0; k < N; k++) begin
          @(posedge clk);
          @(negedge clk);
          if (k < M) push(k);
          y_i = ay[k]; cb_i = acb[k]; cr_i = acr[k];
          hblank_i = ahb[k]; vblank_i = avb[k]; field_i = af[k];
          @(posedge clk);
        end
      end
      begin
        int n = 0;
        int sd = 0;
        int pd = 0;
        while (sd < 2 * M || pd < M) begin
          @(posedge clk);
          n++;
          @(negedge clk);
          if (n >= 7 && sd < 2 * M) begin
            chk(stq.pop_front(), ser_o, sq.pop_front());
            sd++;
          end
          if (n >= 8 && n % 2 == 0 && pd < M) begin
            logic [29:0] e;
            string t;
            e = pq.pop_front();
            t = ptq.pop_front();
            chk(t, y_o, e[29:20]);
            chk(t, u_o, e[19:10]);
            chk(t, v_o, e[9:0]);
            pd++;
          end
        end
      end
    join
  endtask

  initial begin
    run(1'b0, 1'b0, 1'b0);
    run(1'b1, 1'b0, 1'b0);
    run(1'b1, 1'b1, 1'b0);
    run(1'b1, 1'b1, 1'b1);
    run(1'b0, 1'b1, 1'b1);
    run(1'b1, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule